// File: doc/BRIEF.md
# Memory Protection Descriptor File with Violation Capture

This block is the storage side of a memory protection unit. It keeps a bank of region descriptors and, for every slave port, a record of the first access that was refused there. Software and the debugger reach all of it through one register port, and each request on that port carries the number of the master that issued it. The permission checker, which sits outside this block, reads the descriptors from dedicated output buses. When the checker refuses an access it raises a one-cycle violation pulse together with the details of that access.

Each region descriptor has four words: a start bound, an end bound, a rights word and a valid bit. Bounds are kept at 32-byte granularity. Region 0 is partly locked against the core (master 0). The core cannot move the bounds of region 0, and it cannot change the rights field of the debugger (master 1) in that region. Because of this lock, the debugger keeps access to the whole address space. The block also provides a global enable bit, a read-only information register, and per-slave error flags that are cleared by writing 1.

Register map: CTRL at 0x00, INFO at 0x01. The error address of slave s is at 0x40+2s and its error detail at 0x41+2s. Word w of region r is at 0x80+4r+w. In the rights word, master m<4 owns bits [6m+5:6m] and master m>=4 owns bits [2(m-4)+25:2(m-4)+24]. The debugger field is therefore bits [11:6].

Top module: `pdf_desc_file`

## Requirements
- R1: After reset, region 0 reads start 0x00000000, end 0xFFFFFFFF, rights 0xFF1C71C7 (full rights for every master) and valid 1. Every other region has valid 0. CTRL reads 0x00000001, `mpu_en` is 1 and all error flags are clear.
- R2: A descriptor write takes effect on the next clock, except where R3 or R4 block it. A start word reads back with bits [4:0] forced to 0, and an end word reads back with bits [4:0] forced to 1.
- R3: Writes from master 0 to the start or end word of region 0 (0x80, 0x81) are ignored. Master 1 and the other masters can write them.
- R4: A write from master 0 to the rights word of region 0 (0x82) keeps bits [11:6] and takes the written value in all other bits. A write from any other master replaces the whole word.
- R5: Bit 0 of word 3 is the region valid bit and drives `rgn_valid`. Bit 0 of CTRL is the global enable and drives `mpu_en`.
- R6: INFO (0x01) is read-only. Bits [1:0] hold the region count code (0 = 8, 1 = 12, 2 = 16 regions), bits [7:4] the revision and bits [11:8] the slave count. With the defaults it reads 0x00000530.
- R7: A violation pulse on slave s while that slave's flag is clear does two things on the next clock. It sets the flag, which is CTRL bit 16+s. It also stores the error address, and the detail word holds master in [3:0], attribute in [5:4], write in [6], class in [9:8] and process id in [23:16].
- R8: While a slave's flag is set, further violations on that slave leave its address and detail words unchanged.
- R9: Writing CTRL with bit 16+s = 1 clears flag s, and a 0 in that bit leaves the flag as it is. If a clear and a violation on the same slave arrive in the same cycle, the violation is captured and the flag stays set.
- R10: A read returns its data on `rd_data` one clock after the request, and `rd_data` holds its value when there is no read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_master | input | MST_W | Master issuing the request |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one clock after the request |
| viol_valid | input | NS | Violation pulse per slave port |
| viol_master | input | NS*MST_W | Faulting master per slave |
| viol_attr | input | NS*2 | Attribute code per slave |
| viol_write | input | NS | 1 = write, 0 = read, per slave |
| viol_class | input | NS*2 | Violation class per slave |
| viol_addr | input | NS*32 | Faulting address per slave |
| viol_pid | input | NS*8 | Process identifier per slave |
| mpu_en | output | 1 | Global enable |
| rgn_valid | output | NR | Region valid bits |
| rgn_start | output | NR*32 | Region start bounds |
| rgn_end | output | NR*32 | Region end bounds |
| rgn_rights | output | NR*32 | Region rights words |

## Verification
The assertions assume that a violation pulse on a slave comes with stable, meaningful detail inputs in the same cycle. They also assume that register requests stay within the 8-bit word map, with the master number on `req_master`. The bench holds every violation pulse and every request to a single cycle, driven on the falling edge. It picks random masters, regions, words and slaves within the configured counts, and it keeps random clears out of the cycles that carry violations, so the R9 race is tested only in one directed case.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef struct packed {
        logic [26:0] base;
        logic [26:0] limit;
        logic [31:0] rights;
        logic        valid;
    } region_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  pid;
        logic [1:0]  vclass;
        logic        wr;
        logic [1:0]  attr;
        logic [3:0]  master;
    } err_info_t;

    localparam logic [3:0]  CORE_ID        = 4'd0;
    localparam logic [31:0] RIGHTS_ALL     = 32'hFF1C_71C7;
    localparam logic [31:0] DBG_FIELD_MASK = 32'h0000_0FC0;

    localparam region_t REGION0_INIT = '{base: '0, limit: '1, rights: RIGHTS_ALL, valid: 1'b1};
    localparam region_t REGION_IDLE  = '{base: '0, limit: '0, rights: '0, valid: 1'b0};

    function automatic logic [1:0] region_code(input int nr);
        return (nr >= 16) ? 2'd2 : (nr >= 12) ? 2'd1 : 2'd0;
    endfunction

endpackage

// File: rtl/pdf_region_bank.sv
module pdf_region_bank
    import pdf_pkg::*;
#(
    parameter int NR = 8,
    parameter int RW = $clog2(NR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_master,
    input  logic [RW-1:0]        wr_region,
    input  logic [1:0]           wr_word,
    input  logic [31:0]          wr_data,
    output region_t [NR-1:0]     bank_o
);

    region_t [NR-1:0] bank_d, bank_q;
    logic             locked;

    assign locked = (wr_region == '0) && (wr_master == CORE_ID);

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (wr_word)
                2'd0: if (!locked) bank_d[wr_region].base  = wr_data[31:5];
                2'd1: if (!locked) bank_d[wr_region].limit = wr_data[31:5];
                2'd2: begin
                    if (locked)
                        bank_d[wr_region].rights = (bank_q[wr_region].rights & DBG_FIELD_MASK)
                                                 | (wr_data & ~DBG_FIELD_MASK);
                    else
                        bank_d[wr_region].rights = wr_data;
                end
                default: bank_d[wr_region].valid = wr_data[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++)
                bank_q[i] <= (i == 0) ? REGION0_INIT : REGION_IDLE;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_o = bank_q;

endmodule

// File: rtl/pdf_err_slot.sv
module pdf_err_slot
    import pdf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      viol_i,
    input  err_info_t info_i,
    input  logic      clr_i,
    output logic      flag_o,
    output err_info_t info_o
);

    typedef struct packed {
        logic      flag;
        err_info_t info;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (viol_i && (!slot_q.flag || clr_i)) begin
            slot_d.flag = 1'b1;
            slot_d.info = info_i;
        end else if (clr_i) begin
            slot_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign flag_o = slot_q.flag;
    assign info_o = slot_q.info;

endmodule

// File: rtl/pdf_desc_file.sv
module pdf_desc_file
    import pdf_pkg::*;
#(
    parameter int         NR    = 8,
    parameter int         NS    = 5,
    parameter int         MST_W = 4,
    parameter logic [3:0] REV   = 4'h3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [MST_W-1:0]      req_master,
    input  logic [7:0]            req_addr,
    input  logic [31:0]           req_wdata,
    output logic [31:0]           rd_data,
    input  logic [NS-1:0]         viol_valid,
    input  logic [NS*MST_W-1:0]   viol_master,
    input  logic [NS*2-1:0]       viol_attr,
    input  logic [NS-1:0]         viol_write,
    input  logic [NS*2-1:0]       viol_class,
    input  logic [NS*32-1:0]      viol_addr,
    input  logic [NS*8-1:0]       viol_pid,
    output logic                  mpu_en,
    output logic [NR-1:0]         rgn_valid,
    output logic [NR*32-1:0]      rgn_start,
    output logic [NR*32-1:0]      rgn_end,
    output logic [NR*32-1:0]      rgn_rights
);

    localparam int         RW  = $clog2(NR);
    localparam int         SW  = (NS > 1) ? $clog2(NS) : 1;
    localparam logic [4:0] NR5 = 5'(NR);
    localparam logic [3:0] NS4 = 4'(NS);
    localparam logic [31:0] INFO_WORD = {20'd0, NS4, REV, 2'b00, region_code(NR)};

    typedef struct packed {
        logic        en;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    region_t   [NR-1:0] bank;
    logic      [NS-1:0] err_flag;
    err_info_t [NS-1:0] err_info;
    logic      [NS-1:0] err_clr;

    logic [4:0]  desc_idx;
    logic        desc_hit, ctrl_wr, slot_hit;
    logic [3:0]  slot_idx;
    logic [31:0] rd_mux;
    region_t     sel_rgn;

    assign desc_idx = req_addr[6:2];
    assign desc_hit = req_addr[7] && (desc_idx < NR5);
    assign slot_idx = req_addr[4:1];
    assign slot_hit = (req_addr[7:5] == 3'b010) && (slot_idx < NS4);
    assign ctrl_wr  = req_valid && req_write && (req_addr == 8'h00);
    assign err_clr  = ctrl_wr ? req_wdata[16 +: NS] : '0;

    pdf_region_bank #(.NR(NR), .RW(RW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (req_valid && req_write && desc_hit),
        .wr_master (4'(req_master)),
        .wr_region (desc_idx[RW-1:0]),
        .wr_word   (req_addr[1:0]),
        .wr_data   (req_wdata),
        .bank_o    (bank)
    );

    for (genvar s = 0; s < NS; s++) begin : g_slot
        err_info_t cap;
        assign cap = '{addr:   viol_addr[s*32 +: 32],
                       pid:    viol_pid[s*8 +: 8],
                       vclass: viol_class[s*2 +: 2],
                       wr:     viol_write[s],
                       attr:   viol_attr[s*2 +: 2],
                       master: 4'(viol_master[s*MST_W +: MST_W])};
        pdf_err_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .viol_i (viol_valid[s]),
            .info_i (cap),
            .clr_i  (err_clr[s]),
            .flag_o (err_flag[s]),
            .info_o (err_info[s])
        );
    end

    for (genvar r = 0; r < NR; r++) begin : g_rgn_out
        assign rgn_valid[r]           = bank[r].valid;
        assign rgn_start[r*32 +: 32]  = {bank[r].base, 5'h00};
        assign rgn_end[r*32 +: 32]    = {bank[r].limit, 5'h1F};
        assign rgn_rights[r*32 +: 32] = bank[r].rights;
    end

    assign sel_rgn = bank[desc_idx[RW-1:0]];

    always_comb begin
        rd_mux = '0;
        if (desc_hit) begin
            case (req_addr[1:0])
                2'd0:    rd_mux = {sel_rgn.base, 5'h00};
                2'd1:    rd_mux = {sel_rgn.limit, 5'h1F};
                2'd2:    rd_mux = sel_rgn.rights;
                default: rd_mux = {31'd0, sel_rgn.valid};
            endcase
        end else if (slot_hit) begin
            if (!req_addr[0])
                rd_mux = err_info[slot_idx[SW-1:0]].addr;
            else
                rd_mux = {8'd0, err_info[slot_idx[SW-1:0]].pid, 6'd0,
                          err_info[slot_idx[SW-1:0]].vclass, 1'b0,
                          err_info[slot_idx[SW-1:0]].wr,
                          err_info[slot_idx[SW-1:0]].attr,
                          err_info[slot_idx[SW-1:0]].master};
        end else if (req_addr == 8'h00) begin
            rd_mux[0]        = st_q.en;
            rd_mux[16 +: NS] = err_flag;
        end else if (req_addr == 8'h01) begin
            rd_mux = INFO_WORD;
        end
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_wr)                 st_d.en    = req_wdata[0];
        if (req_valid && !req_write) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b1, rdata: '0};
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign mpu_en  = st_q.en;

endmodule

module pdf_desc_file_chk
    import pdf_pkg::*;
#(
    parameter int NR    = 8,
    parameter int NS    = 5,
    parameter int MST_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [MST_W-1:0]     req_master,
    input logic [7:0]           req_addr,
    input logic [31:0]          req_wdata,
    input logic [NS-1:0]        viol_valid,
    input logic                 mpu_en,
    input logic [NR*32-1:0]     rgn_start,
    input logic [NR*32-1:0]     rgn_end,
    input logic [NR*32-1:0]     rgn_rights,
    input logic [NS-1:0]        err_flag,
    input err_info_t [NS-1:0]   err_info
);

    logic core_wr;
    assign core_wr = req_valid && req_write && (req_master == '0);

    // R3
    r0_bounds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && (req_addr == 8'h80 || req_addr == 8'h81))
        |=> ($stable(rgn_start[31:0]) && $stable(rgn_end[31:0])));

    // R4
    dbg_field_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && req_addr == 8'h82) |=> $stable(rgn_rights[11:6]));

    // R5
    global_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 8'h00) |=> (mpu_en == $past(req_wdata[0])));

    for (genvar s = 0; s < NS; s++) begin : g_slot_chk
        logic clr_s;
        assign clr_s = req_valid && req_write && (req_addr == 8'h00) && req_wdata[16+s];

        // R7
        flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!err_flag[s] && !viol_valid[s]) |=> !err_flag[s]);

        // R8
        detail_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_flag[s] && !clr_s) |=> ($stable(err_info[s]) && err_flag[s]));

        // R9
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_s && !viol_valid[s]) |=> !err_flag[s]);
    end

endmodule

bind pdf_desc_file pdf_desc_file_chk #(.NR(NR), .NS(NS), .MST_W(MST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_master (req_master),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .viol_valid (viol_valid),
    .mpu_en     (mpu_en),
    .rgn_start  (rgn_start),
    .rgn_end    (rgn_end),
    .rgn_rights (rgn_rights),
    .err_flag   (err_flag),
    .err_info   (err_info)
);

// File: tb/tb_pdf_desc_file.sv
`timescale 1ns/1ps
module tb_pdf_desc_file;

    localparam int NR = 8;
    localparam int NS = 5;
    localparam int MW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [MW-1:0]     req_master = '0;
    logic [7:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic [NS-1:0]     viol_valid = '0;
    logic [NS*MW-1:0]  viol_master = '0;
    logic [NS*2-1:0]   viol_attr = '0;
    logic [NS-1:0]     viol_write = '0;
    logic [NS*2-1:0]   viol_class = '0;
    logic [NS*32-1:0]  viol_addr = '0;
    logic [NS*8-1:0]   viol_pid = '0;
    logic              mpu_en;
    logic [NR-1:0]     rgn_valid;
    logic [NR*32-1:0]  rgn_start, rgn_end, rgn_rights;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_start [NR];
    logic [31:0] m_end   [NR];
    logic [31:0] m_rights[NR];
    logic        m_valid [NR];
    logic        m_en;
    logic        m_flag  [NS];
    logic [31:0] m_eaddr [NS];
    logic [31:0] m_edet  [NS];

    always #5 clk = ~clk;

    pdf_desc_file #(.NR(NR), .NS(NS), .MST_W(MW)) dut (.*);

    function automatic logic [31:0] detail_word(input logic [3:0] m, input logic [1:0] at,
                                                input logic w, input logic [1:0] c, input logic [7:0] p);
        return {8'd0, p, 6'd0, c, 1'b0, w, at, m};
    endfunction

    function automatic logic [31:0] ctrl_word();
        logic [31:0] v = '0;
        v[0] = m_en;
        for (int s = 0; s < NS; s++) v[16+s] = m_flag[s];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] m, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_master = m; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic set_viol(input int s, input logic [3:0] m, input logic [1:0] at, input logic w,
                            input logic [1:0] c, input logic [31:0] ad, input logic [7:0] p);
        viol_valid[s] = 1'b1;
        viol_master[s*MW +: MW] = m;
        viol_attr[s*2 +: 2] = at;
        viol_write[s] = w;
        viol_class[s*2 +: 2] = c;
        viol_addr[s*32 +: 32] = ad;
        viol_pid[s*8 +: 8] = p;
    endtask

    task automatic viol(input int s, input logic [3:0] m, input logic [1:0] at, input logic w,
                        input logic [1:0] c, input logic [31:0] ad, input logic [7:0] p);
        @(negedge clk);
        set_viol(s, m, at, w, c, ad, p);
        @(negedge clk);
        viol_valid = '0;
        if (!m_flag[s]) begin
            m_flag[s]  = 1'b1;
            m_eaddr[s] = ad;
            m_edet[s]  = detail_word(m, at, w, c, p);
        end
    endtask

    // model of a descriptor write
    task automatic model_desc(input logic [3:0] m, input int r, input int w, input logic [31:0] d);
        bit lock = (r == 0) && (m == 4'd0);
        case (w)
            0: if (!lock) m_start[r] = d & 32'hFFFF_FFE0;
            1: if (!lock) m_end[r]   = d | 32'h0000_001F;
            2: m_rights[r] = lock ? ((m_rights[r] & 32'h0000_0FC0) | (d & ~32'h0000_0FC0)) : d;
            default: m_valid[r] = d[0];
        endcase
    endtask

    task automatic dwr(input logic [3:0] m, input int r, input int w, input logic [31:0] d);
        wr(m, 8'(8'h80 + r*4 + w), d);
        model_desc(m, r, w, d);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        for (int r = 0; r < NR; r++) begin
            rd(8'(8'h80 + r*4 + 0), v); check({tag, " start"},  v, m_start[r]);
            rd(8'(8'h80 + r*4 + 1), v); check({tag, " end"},    v, m_end[r]);
            rd(8'(8'h80 + r*4 + 2), v); check({tag, " rights"}, v, m_rights[r]);
            rd(8'(8'h80 + r*4 + 3), v); check({tag, " valid"},  v, {31'd0, m_valid[r]});
            check({tag, " rgn_valid port"}, {31'd0, rgn_valid[r]}, {31'd0, m_valid[r]});
        end
    endtask

    task automatic check_errs(input string tag);
        logic [31:0] v;
        rd(8'h00, v); check({tag, " CTRL"}, v, ctrl_word());
        for (int s = 0; s < NS; s++) begin
            if (m_flag[s]) begin
                rd(8'(8'h40 + 2*s), v); check({tag, " err addr"},   v, m_eaddr[s]);
                rd(8'(8'h41 + 2*s), v); check({tag, " err detail"}, v, m_edet[s]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, hold;
        void'($urandom(32'd20240611));
        for (int r = 0; r < NR; r++) begin
            m_start[r] = 32'h0; m_end[r] = (r == 0) ? 32'hFFFF_FFFF : 32'h1F;
            m_rights[r] = (r == 0) ? 32'hFF1C_71C7 : 32'h0; m_valid[r] = (r == 0);
        end
        m_en = 1'b1;
        for (int s = 0; s < NS; s++) begin m_flag[s] = 1'b0; m_eaddr[s] = '0; m_edet[s] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mpu_en", {31'd0, mpu_en}, 32'd1);
        check_all("R1");
        rd(8'h00, v); check("R1 CTRL", v, 32'h0000_0001);

        // R6 info register, and writes to it have no effect
        rd(8'h01, v); check("R6 INFO", v, 32'h0000_0530);
        wr(4'd1, 8'h01, 32'hFFFF_FFFF);
        rd(8'h01, v); check("R6 INFO after write", v, 32'h0000_0530);

        // R2 plain descriptor write by a non-core master
        dwr(4'd2, 3, 0, 32'h2000_1234);
        dwr(4'd2, 3, 1, 32'h2000_5600);
        dwr(4'd2, 3, 2, 32'h1234_5678);
        dwr(4'd2, 3, 3, 32'h0000_0001);
        rd(8'h8C, v); check("R2 start low bits 0", v, 32'h2000_1220);
        rd(8'h8D, v); check("R2 end low bits 1", v, 32'h2000_561F);
        check("R2 end port", rgn_end[3*32 +: 32], 32'h2000_561F);

        // R3 core cannot move region 0 bounds
        dwr(4'd0, 0, 0, 32'h1234_5678);
        dwr(4'd0, 0, 1, 32'h0000_0FFF);
        rd(8'h80, v); check("R3 core start ignored", v, 32'h0000_0000);
        rd(8'h81, v); check("R3 core end ignored", v, 32'hFFFF_FFFF);
        dwr(4'd1, 0, 0, 32'h0000_0040);
        rd(8'h80, v); check("R3 debugger start", v, 32'h0000_0040);
        dwr(4'd1, 0, 0, 32'h0000_0000);

        // R4 debugger field kept on core write
        dwr(4'd0, 0, 2, 32'h0000_0000);
        rd(8'h82, v); check("R4 core rights keeps [11:6]", v, 32'h0000_01C0);
        dwr(4'd0, 0, 2, 32'hFFFF_F03F);
        rd(8'h82, v); check("R4 core rights other bits", v, 32'hFFFF_F1FF);
        dwr(4'd1, 0, 2, 32'h0000_0000);
        rd(8'h82, v); check("R4 debugger full write", v, 32'h0000_0000);
        dwr(4'd1, 0, 2, 32'hFF1C_71C7);

        // R5 valid bits
        wr(4'd0, 8'h00, 32'h0); m_en = 1'b0;
        check("R5 mpu_en cleared", {31'd0, mpu_en}, 32'd0);
        wr(4'd0, 8'h00, 32'h1); m_en = 1'b1;
        check("R5 mpu_en set", {31'd0, mpu_en}, 32'd1);
        dwr(4'd0, 0, 3, 32'h0);
        check("R5 region0 valid port", {31'd0, rgn_valid[0]}, 32'd0);
        dwr(4'd0, 0, 3, 32'h1);

        // R7 capture
        viol(2, 4'd6, 2'd1, 1'b1, 2'd2, 32'hDEAD_BEE4, 8'h5A);
        rd(8'h00, v); check("R7 flag bit 18", v, 32'h0004_0001);
        rd(8'h44, v); check("R7 err addr", v, 32'hDEAD_BEE4);
        rd(8'h45, v); check("R7 err detail", v, 32'h005A_0256);

        // R8 frozen
        viol(2, 4'd3, 2'd3, 1'b0, 2'd1, 32'h0000_1000, 8'h11);
        rd(8'h44, v); check("R8 addr frozen", v, 32'hDEAD_BEE4);
        rd(8'h45, v); check("R8 detail frozen", v, 32'h005A_0256);

        // R9 write-one-to-clear
        wr(4'd0, 8'h00, 32'h0000_0001);
        rd(8'h00, v); check("R9 zero leaves flag", v, 32'h0004_0001);
        wr(4'd0, 8'h00, 32'h0004_0001); m_flag[2] = 1'b0;
        rd(8'h00, v); check("R9 one clears flag", v, 32'h0000_0001);
        viol(2, 4'd1, 2'd0, 1'b0, 2'd0, 32'h0000_0100, 8'h00);
        // clear and violation in the same cycle: violation wins
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_master = 4'd0; req_addr = 8'h00; req_wdata = 32'h0004_0001;
        set_viol(2, 4'd7, 2'd2, 1'b1, 2'd3, 32'h8000_0000, 8'hC3);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; viol_valid = '0;
        m_eaddr[2] = 32'h8000_0000; m_edet[2] = detail_word(4'd7, 2'd2, 1'b1, 2'd3, 8'hC3);
        rd(8'h00, v); check("R9 race flag stays", v, 32'h0004_0001);
        rd(8'h44, v); check("R9 race captured", v, 32'h8000_0000);

        // R10 latency, hold and unmapped
        rd(8'h01, v); hold = v;
        repeat (3) @(negedge clk);
        check("R10 rd_data holds", rd_data, hold);
        @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h80;
        check("R10 not before edge", rd_data, hold);
        @(negedge clk); req_valid = 1'b0;
        check("R10 one clock latency", rd_data, m_start[0]);
        rd(8'h60, v); check("R10 unmapped 0x60", v, 32'h0);
        rd(8'hA0, v); check("R10 unmapped region 8", v, 32'h0);
        rd(8'h4A, v); check("R10 unmapped slave 5", v, 32'h0);

        // random descriptor traffic, R2 R3 R4
        for (int i = 0; i < 300; i++) begin
            int r = $urandom_range(NR - 1);
            int w = $urandom_range(3);
            logic [3:0] m = 4'($urandom_range(7));
            if (r == 0 && w == 3) continue;
            dwr(m, r, w, $urandom);
        end
        check_all("R2/R3/R4 random");

        // random violations and clears, R7 R8 R9
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(3) == 0) begin
                logic [31:0] mask = 32'($urandom_range(31)) << 16;
                wr(4'($urandom_range(7)), 8'h00, mask | {31'd0, m_en});
                for (int s = 0; s < NS; s++) if (mask[16+s]) m_flag[s] = 1'b0;
            end else begin
                viol($urandom_range(NS - 1), 4'($urandom_range(15)), 2'($urandom_range(3)),
                     1'($urandom_range(1)), 2'($urandom_range(2)), $urandom, 8'($urandom));
            end
            if (i % 20 == 19) check_errs("R7/R8/R9 random");
        end
        check_errs("R7/R8/R9 final");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule